// File: doc/BRIEF.md
# Word-Addressed Data Memory with Byte Loads

This block is the data storage port of a small processor. It holds 32-bit words, one per location, and each location is reached by a word index. The processor presents the byte address it computed. The block takes the word index from that address and uses the two lowest address bits as a byte lane inside the word. Bytes inside a stored word are numbered little-endian, so lane 0 is the least significant byte.

Four access kinds are served. A word load returns the whole stored word. A word store replaces the whole word at the next rising clock edge. A signed byte load and an unsigned byte load each return one lane, sign-extended or zero-extended to 32 bits. There is no byte store. Reads are combinational. The storage is a register array whose depth is a parameter. When the depth is smaller than the 24-bit word space, only the low index bits pick the location.

Top module: `wdmem_byteload`

## Requirements
- R1: While reset is low, every location is cleared. After reset, a word load from any location returns 0.
- R2: With acc_en high and acc_kind = 2'b11 (word store), wr_data is written to the location chosen by byte_addr at the rising clock edge. A later word load (acc_kind = 2'b00) from that location returns it.
- R3: A word load ignores byte_addr[1:0]. All four byte offsets inside one word return the same 32-bit value.
- R4: A signed byte load (acc_kind = 2'b01) returns lane byte_addr[1:0] of the word, where lane k is bits 8k+7:8k. Bits 31:8 of the result copy bit 7 of that lane.
- R5: An unsigned byte load (acc_kind = 2'b10) returns the same lane as R4, with bits 31:8 of the result zero.
- R6: A location changes only through a word store with acc_en high. A store presented with acc_en low leaves the memory unchanged.
- R7: rd_data is 0 whenever acc_en is low or acc_kind is the word store code.
- R8: The location is byte_addr[IDX_W+1:2], where IDX_W = log2(DEPTH). Address bits above that slice are ignored, so addresses that differ only there reach the same location.
- R9: Reads are combinational. A change of byte_addr or acc_kind changes rd_data with no clock edge, and a stored word can be read as soon as the store edge has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores take effect on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset that clears the array |
| acc_en | input | 1 | Access strobe |
| acc_kind | input | 2 | Access kind: 00 word load, 01 signed byte load, 10 unsigned byte load, 11 word store |
| byte_addr | input | 32 | Byte address from the processor |
| wr_data | input | 32 | Word to store |
| rd_data | output | 32 | Load result |

## Verification
The bench builds the block with the default parameters: 32-bit data, 32-bit byte address, a 24-bit word space and a 64-word array. With 64 words, only byte address bits 7:2 select a location. This makes aliasing reachable with small addresses such as 0x104 against 0x4, and with a high bit such as bit 30. The 32-bit data width gives four lanes, so every lane value of a single test word is checked for both sign and zero extension, including lanes whose top bit is set and lanes whose top bit is clear.

// File: rtl/wdmem_pkg.sv
package wdmem_pkg;

   typedef enum logic [1:0] {
      ACC_LW  = 2'b00,
      ACC_LB  = 2'b01,
      ACC_LBU = 2'b10,
      ACC_SW  = 2'b11
   } acc_kind_e;

   localparam int LANE_BITS = 8;

endpackage

// File: rtl/wdmem_addr_split.sv
module wdmem_addr_split #(
   parameter int BYTE_AW = 32,
   parameter int WORD_AW = 24,
   parameter int LANE_W  = 2,
   parameter int IDX_W   = 6
) (
   input  logic [BYTE_AW-1:0] byte_addr,
   output logic [IDX_W-1:0]   row_idx,
   output logic [LANE_W-1:0]  lane_sel
);

   localparam int TOP_BIT = LANE_W + WORD_AW;

   assign lane_sel = byte_addr[LANE_W-1:0];
   assign row_idx  = byte_addr[LANE_W+IDX_W-1:LANE_W];

   // Bits that never reach the array: part of the word index beyond the
   // array depth, and anything above the word space.
   generate
      if (IDX_W < WORD_AW && BYTE_AW > TOP_BIT) begin : g_drop_both
         logic addr_unused;
         assign addr_unused = ^{byte_addr[BYTE_AW-1:TOP_BIT],
                                byte_addr[TOP_BIT-1:LANE_W+IDX_W]};
      end else if (IDX_W < WORD_AW) begin : g_drop_mid
         logic addr_unused;
         assign addr_unused = ^byte_addr[TOP_BIT-1:LANE_W+IDX_W];
      end else if (BYTE_AW > TOP_BIT) begin : g_drop_top
         logic addr_unused;
         assign addr_unused = ^byte_addr[BYTE_AW-1:TOP_BIT];
      end
   endgenerate

endmodule

// File: rtl/wdmem_word_array.sv
module wdmem_word_array #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 64,
   parameter int IDX_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  row_idx,
   input  logic [DATA_W-1:0] wr_word,
   output logic [DATA_W-1:0] rd_word
);

   logic [DATA_W-1:0] rows [DEPTH];

   generate
      for (genvar r = 0; r < DEPTH; r++) begin : g_row
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rows[r] <= '0;
            end else if (wr_en && row_idx == IDX_W'(r)) begin
               rows[r] <= wr_word;
            end
         end
      end
   endgenerate

   assign rd_word = rows[row_idx];

endmodule

// File: rtl/wdmem_load_fmt.sv
module wdmem_load_fmt
   import wdmem_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANES  = 4,
   parameter int LANE_W = 2
) (
   input  logic              acc_en,
   input  acc_kind_e         kind,
   input  logic [LANE_W-1:0] lane_sel,
   input  logic [DATA_W-1:0] word_in,
   output logic [DATA_W-1:0] result
);

   logic [LANE_BITS-1:0] lane_val [LANES];
   logic [LANE_BITS-1:0] picked;

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         assign lane_val[k] = word_in[k*LANE_BITS +: LANE_BITS];
      end
   endgenerate

   assign picked = lane_val[lane_sel];

   always_comb begin
      result = '0;
      if (acc_en) begin
         unique case (kind)
            ACC_LW:  result = word_in;
            ACC_LB:  result = {{(DATA_W-LANE_BITS){picked[LANE_BITS-1]}}, picked};
            ACC_LBU: result = {{(DATA_W-LANE_BITS){1'b0}}, picked};
            ACC_SW:  result = '0;
         endcase
      end
   end

endmodule

// File: rtl/wdmem_byteload.sv
module wdmem_byteload
   import wdmem_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int BYTE_AW = 32,
   parameter int WORD_AW = 24,
   parameter int DEPTH   = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_en,
   input  logic [1:0]         acc_kind,
   input  logic [BYTE_AW-1:0] byte_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_data
);

   localparam int LANES  = DATA_W / LANE_BITS;
   localparam int LANE_W = $clog2(LANES);
   localparam int IDX_W  = $clog2(DEPTH);

   generate
      if (DATA_W % LANE_BITS != 0 || LANES < 2) begin : g_bad_width
         $error("wdmem_byteload: DATA_W must be a multiple of 8 and at least 16");
      end
      if ((1 << LANE_W) != LANES) begin : g_bad_lanes
         $error("wdmem_byteload: lane count must be a power of two");
      end
      if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("wdmem_byteload: DEPTH must be a power of two, at least 2");
      end
      if (IDX_W > WORD_AW) begin : g_bad_space
         $error("wdmem_byteload: DEPTH exceeds the word address space");
      end
      if (LANE_W + WORD_AW > BYTE_AW) begin : g_bad_addr
         $error("wdmem_byteload: byte address too narrow for the word space");
      end
   endgenerate

   acc_kind_e         kind;
   logic [IDX_W-1:0]  row_idx;
   logic [LANE_W-1:0] lane_sel;
   logic [DATA_W-1:0] stored_word;
   logic              store_now;

   assign kind      = acc_kind_e'(acc_kind);
   assign store_now = acc_en && (kind == ACC_SW);

   wdmem_addr_split #(
      .BYTE_AW (BYTE_AW),
      .WORD_AW (WORD_AW),
      .LANE_W  (LANE_W),
      .IDX_W   (IDX_W)
   ) split_i (
      .byte_addr (byte_addr),
      .row_idx   (row_idx),
      .lane_sel  (lane_sel)
   );

   wdmem_word_array #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .IDX_W  (IDX_W)
   ) array_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (store_now),
      .row_idx (row_idx),
      .wr_word (wr_data),
      .rd_word (stored_word)
   );

   wdmem_load_fmt #(
      .DATA_W (DATA_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) fmt_i (
      .acc_en   (acc_en),
      .kind     (kind),
      .lane_sel (lane_sel),
      .word_in  (stored_word),
      .result   (rd_data)
   );

endmodule

// File: rtl/wdmem_byteload_chk.sv
module wdmem_byteload_chk #(
   parameter int DATA_W  = 32,
   parameter int BYTE_AW = 32,
   parameter int DEPTH   = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               acc_en,
   input logic [1:0]         acc_kind,
   input logic [BYTE_AW-1:0] byte_addr,
   input logic [DATA_W-1:0]  wr_data,
   input logic [DATA_W-1:0]  rd_data
);

   localparam int LANE_W = $clog2(DATA_W / 8);
   localparam int IDX_W  = $clog2(DEPTH);

   logic [IDX_W-1:0] idx;
   logic             addr_unused;
   assign idx         = byte_addr[LANE_W+IDX_W-1:LANE_W];
   assign addr_unused = ^{byte_addr[BYTE_AW-1:LANE_W+IDX_W], byte_addr[LANE_W-1:0]};

   // R7: no load result without a load
   assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_en || acc_kind == 2'b11) |-> rd_data == '0);

   // R4: signed byte load fills the upper bits with the lane sign
   assert_lb_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_kind == 2'b01) |-> rd_data[DATA_W-1:8] == {(DATA_W-8){rd_data[7]}});

   // R5: unsigned byte load has zero upper bits
   assert_lbu_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_kind == 2'b10) |-> rd_data[DATA_W-1:8] == '0);

   // R2: a store is visible to a word load of the same location next cycle
   assert_store_then_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_kind == 2'b11) |=>
      (!(acc_en && acc_kind == 2'b00 && idx == $past(idx)) || rd_data == $past(wr_data)));

   // R6: without a store, a word load of the same location repeats its value
   assert_hold_no_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_kind == 2'b00) |=>
      (!(acc_en && acc_kind == 2'b00 && idx == $past(idx)) || rd_data == $past(rd_data)));

endmodule

bind wdmem_byteload wdmem_byteload_chk #(
   .DATA_W  (DATA_W),
   .BYTE_AW (BYTE_AW),
   .DEPTH   (DEPTH)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_en    (acc_en),
   .acc_kind  (acc_kind),
   .byte_addr (byte_addr),
   .wr_data   (wr_data),
   .rd_data   (rd_data)
);

// File: tb/wdmem_byteload_tb_top.sv
`timescale 1ns/1ps
module wdmem_byteload_tb_top;

   localparam logic [1:0] K_LW  = 2'b00;
   localparam logic [1:0] K_LB  = 2'b01;
   localparam logic [1:0] K_LBU = 2'b10;
   localparam logic [1:0] K_SW  = 2'b11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_en = 1'b0;
   logic [1:0]  acc_kind = K_LW;
   logic [31:0] byte_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   wdmem_byteload dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_en    (acc_en),
      .acc_kind  (acc_kind),
      .byte_addr (byte_addr),
      .wr_data   (wr_data),
      .rd_data   (rd_data)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   task automatic do_store(input logic [31:0] a, input logic [31:0] d, input logic en);
      @(negedge clk);
      acc_en = en; acc_kind = K_SW; byte_addr = a; wr_data = d;
      @(posedge clk);
      #1;
      acc_en = 1'b0;
   endtask

   task automatic do_load(input logic [1:0] k, input logic [31:0] a, output logic [31:0] v);
      @(negedge clk);
      acc_en = 1'b1; acc_kind = k; byte_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int i = 0; i < 64; i += 9) begin
         do_load(K_LW, 32'(i * 4), v);
         check("R1 reset clears", v, 32'h0);
      end
   endtask

   task automatic t_word_store();
      logic [31:0] v;
      do_store(32'h0000_0010, 32'hDEAD_BEEF, 1'b1);
      do_store(32'h0000_00FC, 32'h1234_5678, 1'b1);
      do_load(K_LW, 32'h0000_0010, v);
      check("R2 word store/load", v, 32'hDEAD_BEEF);
      do_load(K_LW, 32'h0000_00FC, v);
      check("R2 word store/load top row", v, 32'h1234_5678);
   endtask

   task automatic t_lw_offset();
      logic [31:0] v;
      for (int o = 1; o < 4; o++) begin
         do_load(K_LW, 32'h0000_0010 + 32'(o), v);
         check("R3 lw ignores low bits", v, 32'hDEAD_BEEF);
      end
   endtask

   task automatic t_lb();
      logic [31:0] v;
      logic [31:0] exp [4] = '{32'hFFFF_FFFE, 32'h0000_0001, 32'h0000_007F, 32'hFFFF_FF80};
      do_store(32'h0000_000C, 32'h807F_01FE, 1'b1);
      for (int k = 0; k < 4; k++) begin
         do_load(K_LB, 32'h0000_000C + 32'(k), v);
         check("R4 lb lane sign extend", v, exp[k]);
      end
   endtask

   task automatic t_lbu();
      logic [31:0] v;
      logic [31:0] exp [4] = '{32'h0000_00FE, 32'h0000_0001, 32'h0000_007F, 32'h0000_0080};
      for (int k = 0; k < 4; k++) begin
         do_load(K_LBU, 32'h0000_000C + 32'(k), v);
         check("R5 lbu lane zero extend", v, exp[k]);
      end
   endtask

   task automatic t_store_gated();
      logic [31:0] v;
      do_store(32'h0000_0014, 32'hAAAA_5555, 1'b0);
      do_load(K_LW, 32'h0000_0014, v);
      check("R6 gated store no effect", v, 32'h0);
      do_store(32'h0000_0010, 32'h0BAD_F00D, 1'b0);
      do_load(K_LW, 32'h0000_0010, v);
      check("R6 gated store keeps old word", v, 32'hDEAD_BEEF);
   endtask

   task automatic t_idle_zero();
      @(negedge clk);
      acc_en = 1'b0; acc_kind = K_LW; byte_addr = 32'h10;
      #1;
      check("R7 idle strobe zero", rd_data, 32'h0);
      acc_en = 1'b1; acc_kind = K_SW; wr_data = 32'hDEAD_BEEF;
      #1;
      check("R7 store kind zero", rd_data, 32'h0);
      acc_en = 1'b0;
      @(posedge clk);
      #1;
   endtask

   task automatic t_alias();
      logic [31:0] v;
      do_store(32'h0000_0104, 32'h1111_2222, 1'b1);
      do_load(K_LW, 32'h0000_0004, v);
      check("R8 alias above depth", v, 32'h1111_2222);
      do_store(32'h4000_0008, 32'h3333_4444, 1'b1);
      do_load(K_LW, 32'h0000_0008, v);
      check("R8 high bits ignored", v, 32'h3333_4444);
   endtask

   task automatic t_comb_read();
      @(negedge clk);
      acc_en = 1'b1; acc_kind = K_SW; byte_addr = 32'h20; wr_data = 32'hCAFE_0102;
      @(posedge clk);
      #0.5;
      acc_kind = K_LW;
      #0.5;
      check("R9 read right after store edge", rd_data, 32'hCAFE_0102);
      byte_addr = 32'h10;
      #0.5;
      check("R9 address change no edge", rd_data, 32'hDEAD_BEEF);
      acc_kind = K_LBU; byte_addr = 32'h23;
      #0.5;
      check("R9 kind change no edge", rd_data, 32'h0000_00CA);
      acc_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      t_reset();
      t_word_store();
      t_lw_offset();
      t_lb();
      t_lbu();
      t_store_gated();
      t_idle_zero();
      t_alias();
      t_comb_read();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule